// File: doc/BRIEF.md
# Pipelined Boolean-Masked Adder-Subtractor

This block adds or subtracts two WIDTH-bit integers that arrive as two Boolean shares each. The true value of an operand is the XOR of its two shares. The result leaves in the same two-share form. Inside the datapath the two shares of a value are never XORed together. The sum bit of each slice is a share-wise XOR of the operand and carry shares, so it needs no randomness. The carry function (majority of a, b and carry-in) is built from three masked AND gadgets, one for each product term. Each gadget draws one fresh random bit per cycle and registers its cross-share products before they are combined.

Each bit slice adds one pipeline stage. The operand bits enter through delay lines skewed by bit position, so that every bit meets its carry in the right stage. The result bits leave through a matching deskew. A new operation can be accepted every cycle. When the subtract flag is set, share 0 of operand B is inverted bitwise and the first carry-in is forced to one, so the unit computes A minus B in two's complement.

Both the input and the output side use valid/ready handshakes. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. Back-pressure stalls the whole pipeline as one unit. Nothing is dropped or reordered. While the pipeline is stalled, no random bits are consumed.

Top module: `masked_addsub`

## Requirements
- R1: With `in_sub` low, the XOR of `out_sum_s0` and `out_sum_s1` equals (A + B) mod 2^WIDTH, where A and B are the XOR of their respective input shares.
- R2: With `in_sub` high, the recombined result equals (A - B) mod 2^WIDTH. This is done by inverting share 0 of B and forcing the least significant carry-in to 1.
- R3: When `out_ready` is held high, a result becomes visible on the outputs after the WIDTH-th rising edge, counting the edge that accepted the operation. Results leave in acceptance order.
- R4: Whenever `out_ready` is high, `in_ready` is high, so one operation can be accepted on every cycle.
- R5: While `out_valid` is high and `out_ready` is low, on the next cycle `out_valid` stays high and both result shares are unchanged.
- R6: `in_ready` is low whenever `out_valid` is high and `out_ready` is low. Operations already inside the pipeline are all delivered once `out_ready` returns high.
- R7: After reset, `out_valid` is low, both result shares are zero, and `in_ready` is high.
- R8: The recombined result depends only on the recombined operand values and `in_sub`. It does not depend on how the operands are split into shares or on the values of `in_rnd`.
- R9: Each carry AND gadget produces output shares whose XOR equals the AND of its recombined inputs, registered on the previous enabled edge. The gadget holds its outputs while the pipeline is stalled. A carry can therefore ripple through every bit position (for example 0xFF + 0x01 wraps to 0x00 at WIDTH = 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_sub | input | 1 | 1 selects A - B, 0 selects A + B |
| in_a_s0 | input | WIDTH | Operand A, share 0 |
| in_a_s1 | input | WIDTH | Operand A, share 1 |
| in_b_s0 | input | WIDTH | Operand B, share 0 |
| in_b_s1 | input | WIDTH | Operand B, share 1 |
| in_rnd | input | 3*(WIDTH-1) | Fresh random bits, three per carry-producing slice, used on advancing cycles |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum_s0 | output | WIDTH | Result, share 0 |
| out_sum_s1 | output | WIDTH | Result, share 1 |

## Verification
The bench builds the block with WIDTH = 8. At that width the full-length carry ripple, both wrap directions (0xFF + 0x01 and 0x00 - 0x01) and the sign-boundary cases at 0x7F and 0x80 can all be written as exact hand-computed vectors. The short eight-stage pipeline lets the bench fill the pipeline completely under back-pressure and then drain it within a few cycles. Operand shares and random bits are redrawn on every operation, and the shares are recombined only in the bench. This exposes any dependence of the result on the particular split.

// File: rtl/masked_arith_pkg.sv
package masked_arith_pkg;

  // One bit held as two Boolean shares; value = s0 ^ s1.
  typedef struct packed {
    logic s0;
    logic s1;
  } share_bit_t;

  // Fresh random bits per carry-producing slice: one per AND gadget.
  localparam int unsigned RND_PER_SLICE = 3;

endpackage

// File: rtl/share_delay.sv
module share_delay #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(DEPTH); k++) stg[k] <= '0;
    end else if (en) begin
      stg[0] <= d;
      for (int k = 1; k < int'(DEPTH); k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/mask_and_gadget.sv
module mask_and_gadget
  import masked_arith_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  share_bit_t x,
  input  share_bit_t y,
  input  logic       rnd,
  output share_bit_t q
);

  // Cross-share products and the fresh bit are registered first,
  // so the XOR chain below only ever sees stable, aligned inputs.
  logic p00, p01, p10, p11, r_q;
  logic z;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p00 <= 1'b0;
      p01 <= 1'b0;
      p10 <= 1'b0;
      p11 <= 1'b0;
      r_q <= 1'b0;
    end else if (en) begin
      p00 <= x.s0 & y.s0;
      p01 <= x.s0 & y.s1;
      p10 <= x.s1 & y.s0;
      p11 <= x.s1 & y.s1;
      r_q <= rnd;
    end
  end

  // Chain starts from the random bit so every partial sum stays masked.
  assign z    = (((r_q ^ p00) ^ p01) ^ p10) ^ p11;
  assign q.s0 = z;
  assign q.s1 = r_q;

  // R9
  gadget_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((q.s0 ^ q.s1) == ($past(x.s0 ^ x.s1) & $past(y.s0 ^ y.s1))));

  // R9
  gadget_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

endmodule

// File: rtl/masked_slice.sv
module masked_slice
  import masked_arith_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  share_bit_t               a,
  input  share_bit_t               b,
  input  share_bit_t               cin,
  input  logic [RND_PER_SLICE-1:0] rnd,
  output share_bit_t               sum,
  output share_bit_t               cout
);

  share_bit_t t_ab, t_ac, t_bc;

  // Linear part: each share handled on its own.
  assign sum.s0 = a.s0 ^ b.s0 ^ cin.s0;
  assign sum.s1 = a.s1 ^ b.s1 ^ cin.s1;

  mask_and_gadget u_and_ab (
    .clk(clk), .rst_n(rst_n), .en(en), .x(a), .y(b),   .rnd(rnd[0]), .q(t_ab));
  mask_and_gadget u_and_ac (
    .clk(clk), .rst_n(rst_n), .en(en), .x(a), .y(cin), .rnd(rnd[1]), .q(t_ac));
  mask_and_gadget u_and_bc (
    .clk(clk), .rst_n(rst_n), .en(en), .x(b), .y(cin), .rnd(rnd[2]), .q(t_bc));

  // Majority = ab ^ ac ^ bc, recombined per share domain.
  assign cout.s0 = t_ab.s0 ^ t_ac.s0 ^ t_bc.s0;
  assign cout.s1 = t_ab.s1 ^ t_ac.s1 ^ t_bc.s1;

endmodule

// File: rtl/masked_addsub.sv
module masked_addsub
  import masked_arith_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned RND_W = RND_PER_SLICE * (WIDTH - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sub,
  input  logic [WIDTH-1:0] in_a_s0,
  input  logic [WIDTH-1:0] in_a_s1,
  input  logic [WIDTH-1:0] in_b_s0,
  input  logic [WIDTH-1:0] in_b_s1,
  input  logic [RND_W-1:0] in_rnd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum_s0,
  output logic [WIDTH-1:0] out_sum_s1
);

  // Whole pipeline moves as one unit; it only stops when a finished
  // result sits at the output unclaimed.
  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // Subtract: complement B on share 0 only, carry-in of one.
  logic [WIDTH-1:0] b_s0_x;
  assign b_s0_x = in_b_s0 ^ {WIDTH{in_sub}};

  share_bit_t a_st [WIDTH];
  share_bit_t b_st [WIDTH];
  share_bit_t cy   [WIDTH];
  share_bit_t sm   [WIDTH];

  assign cy[0] = '{s0: in_sub, s1: 1'b0};

  for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
    // Input skew: bit i waits i stages for its carry.
    if (i == 0) begin : g_noskew
      assign a_st[i] = '{s0: in_a_s0[i], s1: in_a_s1[i]};
      assign b_st[i] = '{s0: b_s0_x[i],  s1: in_b_s1[i]};
    end else begin : g_skew
      logic [3:0] sk;
      share_delay #(.W(4), .DEPTH(i)) u_skew (
        .clk(clk), .rst_n(rst_n), .en(advance),
        .d({in_a_s0[i], in_a_s1[i], b_s0_x[i], in_b_s1[i]}),
        .q(sk));
      assign a_st[i] = '{s0: sk[3], s1: sk[2]};
      assign b_st[i] = '{s0: sk[1], s1: sk[0]};
    end

    // Slice: only bits below the top produce a carry.
    if (i < int'(WIDTH) - 1) begin : g_slice
      masked_slice u_slice (
        .clk(clk), .rst_n(rst_n), .en(advance),
        .a(a_st[i]), .b(b_st[i]), .cin(cy[i]),
        .rnd(in_rnd[RND_PER_SLICE*i +: RND_PER_SLICE]),
        .sum(sm[i]), .cout(cy[i+1]));
    end else begin : g_top
      assign sm[i].s0 = a_st[i].s0 ^ b_st[i].s0 ^ cy[i].s0;
      assign sm[i].s1 = a_st[i].s1 ^ b_st[i].s1 ^ cy[i].s1;
    end

    // Output deskew: lower bits wait for the top bit.
    logic [1:0] dq;
    share_delay #(.W(2), .DEPTH(WIDTH - i)) u_deskew (
      .clk(clk), .rst_n(rst_n), .en(advance),
      .d({sm[i].s0, sm[i].s1}),
      .q(dq));
    assign out_sum_s0[i] = dq[1];
    assign out_sum_s1[i] = dq[0];
  end

  share_delay #(.W(1), .DEPTH(WIDTH)) u_valid (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .d(in_valid), .q(out_valid));

  // R4
  ready_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_sum_s0) && $stable(out_sum_s1)));

endmodule

// File: tb/test_masked_addsub.sv
module test_masked_addsub;

  localparam int W     = 8;
  localparam int RND_W = 3 * (W - 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_sub = 1'b0;
  logic [W-1:0]     in_a_s0 = '0, in_a_s1 = '0, in_b_s0 = '0, in_b_s1 = '0;
  logic [RND_W-1:0] in_rnd = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [W-1:0]     out_sum_s0, out_sum_s1;

  masked_addsub #(.WIDTH(W)) i_masked_addsub (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sub(in_sub),
    .in_a_s0(in_a_s0), .in_a_s1(in_a_s1),
    .in_b_s0(in_b_s0), .in_b_s1(in_b_s1),
    .in_rnd(in_rnd),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum_s0(out_sum_s0), .out_sum_s1(out_sum_s1));

  always #4 clk = ~clk;  // 125 MHz

  // {a, b, sub, expected}
  localparam logic [24:0] VEC [12] = '{
    {8'h00, 8'h00, 1'b0, 8'h00},
    {8'h01, 8'h01, 1'b0, 8'h02},
    {8'hFF, 8'h01, 1'b0, 8'h00},
    {8'h80, 8'h80, 1'b0, 8'h00},
    {8'h5A, 8'h3C, 1'b0, 8'h96},
    {8'h05, 8'h03, 1'b1, 8'h02},
    {8'h00, 8'h01, 1'b1, 8'hFF},
    {8'h80, 8'h01, 1'b1, 8'h7F},
    {8'h3C, 8'h5A, 1'b1, 8'hE2},
    {8'hFF, 8'hFF, 1'b1, 8'h00},
    {8'h7F, 8'h01, 1'b0, 8'h80},
    {8'hAA, 8'h55, 1'b0, 8'hFF}
  };

  int       nchk = 0, nfail = 0, cyc = 0;
  int       wr = 0, rd = 0;
  bit       lat_on = 1'b0;
  logic [W-1:0] exp_q [64];
  int       req_q [64];
  int       acc_q [64];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) in_rnd = RND_W'($urandom);

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL R%0d %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic sub, input logic [W-1:0] expv, input int req);
    @(negedge clk);
    in_a_s0 = W'($urandom);
    in_a_s1 = in_a_s0 ^ a;
    in_b_s0 = W'($urandom);
    in_b_s1 = in_b_s0 ^ b;
    in_sub  = sub;
    in_valid = 1'b1;
    #1;
    if (out_ready) check(in_ready == 1'b1, 4, "in_ready with out_ready high", 32'(in_ready), 1);  // R4
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q[wr] = expv;
    req_q[wr] = req;
    acc_q[wr] = cyc;
    wr++;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Output monitor: recombines shares only here.
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      check((out_sum_s0 ^ out_sum_s1) == exp_q[rd], req_q[rd], "result value",
            32'(out_sum_s0 ^ out_sum_s1), 32'(exp_q[rd]));
      if (lat_on)
        check(cyc - acc_q[rd] == W, 3, "latency", 32'(cyc - acc_q[rd]), W);  // R3
      rd++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, 3, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    #1;
    // R7 reset state
    check(out_valid == 1'b0, 7, "out_valid in reset", 32'(out_valid), 0);
    check(in_ready == 1'b1, 7, "in_ready in reset", 32'(in_ready), 1);
    check(out_sum_s0 == '0, 7, "share0 in reset", 32'(out_sum_s0), 0);
    check(out_sum_s1 == '0, 7, "share1 in reset", 32'(out_sum_s1), 0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    lat_on = 1'b1;

    // Table walk: R1 for adds, R2 for subtracts, streamed back to back.
    foreach (VEC[k]) begin
      send(VEC[k][24:17], VEC[k][16:9], VEC[k][8], VEC[k][7:0], VEC[k][8] ? 2 : 1);
    end

    // R8: same operands, fresh share splits and random bits each time.
    for (int k = 0; k < 4; k++) send(8'h5A, 8'h3C, 1'b0, 8'h96, 8);
    // R9: full carry ripple through every gadget.
    send(8'hFF, 8'hFF, 1'b0, 8'hFE, 9);
    send(8'h01, 8'hFF, 1'b0, 8'h00, 9);

    repeat (W + 4) @(negedge clk);
    #1;
    check(rd == wr, 3, "all streamed results delivered in order", 32'(rd), 32'(wr));

    // Back-pressure: R5 and R6.
    lat_on = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    send(8'h12, 8'h34, 1'b0, 8'h46, 5);
    send(8'h10, 8'h01, 1'b1, 8'h0F, 6);
    repeat (W + 2) @(negedge clk);
    #1;
    check(out_valid == 1'b1, 5, "out_valid held under stall", 32'(out_valid), 1);
    check(in_ready == 1'b0, 6, "in_ready low under stall", 32'(in_ready), 0);
    held = out_sum_s0 ^ out_sum_s1;
    check(held == 8'h46, 5, "stalled result value", 32'(held), 32'h46);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, 5, "out_valid one cycle later", 32'(out_valid), 1);
    check((out_sum_s0 ^ out_sum_s1) == held, 5, "stalled result stable",
          32'(out_sum_s0 ^ out_sum_s1), 32'(held));
    @(negedge clk);
    out_ready = 1'b1;
    repeat (W + 4) @(negedge clk);
    #1;
    check(rd == wr, 6, "pipeline drained after stall", 32'(rd), 32'(wr));

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule